// File: doc/BRIEF.md
# Register-Mapped LPC Access Bridge

This block is a slave on a 64-bit register bus. Software uses it to make single byte, halfword, word or doubleword accesses on a downstream peripheral bus. It does this through three registers: a command register, a data register and a status register. The command register carries a direction flag, a byte count and a 32-bit downstream address. Writing the command register with the read flag set fetches data from downstream. Writing the data register while the latched command has the read flag clear pushes data downstream.

All data is placed inside an 8-byte aligned sector. A sub-doubleword item sits in the data register at the byte lane that matches the low three address bits, not in the least significant bytes. On the downstream side the bridge presents right-justified data and a per-lane byte enable. While a downstream transfer is in flight, the register-bus acknowledge is held back, so any access that follows sees completed state.

A few legacy indices are decoded but have no function. Unknown indices are flagged. An illegal byte count is rejected and flagged.

Top module: `lpc_reg_bridge`

## Requirements
- R1: After reset, reg_ack_o, ds_req_o, size_err_o and unimpl_o are low, and the command and data registers read as zero.
- R2: The register index is reg_addr_i shifted right by 3. Index 0x41 (command) and index 0x42 (data) read back the last value written to them. Index 0x40 (base) reads zero and ignores writes.
- R3: Index 0x43 (status) reads 64'h8000_0000_0000_0000 (done set) and ignores writes.
- R4: Indices 0x12, 0x13 and 0x18 read zero, ignore writes and leave unimpl_o unchanged.
- R5: Any other index reads zero and ignores writes. Any access to such an index sets unimpl_o, which stays set until reset.
- R6: The command fields are: bit 63 = read flag, bits 58:52 = byte count, bits 31:0 = downstream address. A command write with the read flag set and a legal count issues exactly one downstream access with ds_we_o low, at that address.
- R7: A data-register write issues one downstream access with ds_we_o high, using the latched address and count, only when the latched read flag is clear and the count is legal. With the read flag set, the write only latches the data.
- R8: A count is legal only if it is 1, 2, 4 or 8. An illegal count issues no downstream access, leaves the data register unchanged on a read, and sets size_err_o, which stays set until reset.
- R9: On a read, ds_rdata_i carries the bytes right-justified, first byte most significant. Byte i lands in data-register lane (addr mod 8)+i, where lane L occupies bits [63-8L -: 8]. Lanes past 7 are dropped and all other lanes become zero.
- R10: On a write, ds_wdata_o carries right-justified bytes taken from data-register lanes (addr mod 8)+i. Lanes past 7 give zero, and the bits above the count are zero.
- R11: ds_be_o bit L is set exactly for lanes L from (addr mod 8) up to (addr mod 8)+count-1 that lie within 0..7.
- R12: During a downstream access, reg_ack_o stays low. The request fields stay stable until ds_ack_i. reg_ack_o rises in the cycle after the ds_ack_i cycle.
- R13: An access that needs no downstream transfer is acknowledged one cycle after it is accepted. reg_ack_o is always a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request, held until reg_ack_o |
| reg_we_i | input | 1 | 1 = register write, 0 = register read |
| reg_addr_i | input | AW | Register byte address |
| reg_wdata_i | input | 64 | Register write data |
| reg_ack_o | output | 1 | Access completion pulse |
| reg_rdata_o | output | 64 | Read data, valid with reg_ack_o |
| ds_req_o | output | 1 | Downstream request |
| ds_we_o | output | 1 | Downstream direction, 1 = write |
| ds_addr_o | output | 32 | Downstream byte address |
| ds_be_o | output | 8 | Per-lane byte enable, bit L = lane L |
| ds_wdata_o | output | 64 | Right-justified downstream write data |
| ds_ack_i | input | 1 | Downstream completion, one cycle |
| ds_rdata_i | input | 64 | Right-justified downstream read data |
| size_err_o | output | 1 | Sticky illegal-count flag |
| unimpl_o | output | 1 | Sticky unknown-index flag |

## Verification
The assertions assume the following about the inputs:
- The register requester holds reg_req_i and its fields steady until reg_ack_o, and drops the request in the acknowledge cycle.
- ds_ack_i pulses for a single cycle, and only while ds_req_o is high.

The bench keeps within these rules. Its driver raises and lowers the request only between edges, and drops it in the acknowledge cycle. Its downstream model answers only a pending request, with a programmable latency and a one-cycle acknowledge. It never issues a register access while a previous one is still open.

// File: rtl/lpc_bridge_pkg.sv
package lpc_bridge_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned NLANE  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(NLANE);
  localparam int unsigned DS_AW  = 32;

  // command field positions (bit 63 is the first bit of the word)
  localparam int unsigned RD_BIT = 63;
  localparam int unsigned SZ_HI  = 58;
  localparam int unsigned SZ_LO  = 52;
  localparam int unsigned SZ_W   = SZ_HI - SZ_LO + 1;

  localparam logic [7:0] IDX_BASE = 8'h40;
  localparam logic [7:0] IDX_CMD  = 8'h41;
  localparam logic [7:0] IDX_DATA = 8'h42;
  localparam logic [7:0] IDX_STAT = 8'h43;
  localparam logic [7:0] IDX_Q0   = 8'h12;
  localparam logic [7:0] IDX_Q1   = 8'h13;
  localparam logic [7:0] IDX_Q2   = 8'h18;

  localparam logic [DATA_W-1:0] STATUS_DONE = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} bridge_st_e;
endpackage

// File: rtl/lpc_size_check.sv
module lpc_size_check
  import lpc_bridge_pkg::*;
(
  input  logic [SZ_W-1:0]  size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             legal_o,
  output logic [NLANE-1:0] be_o
);
  assign legal_o = ($countones(size_i) == 1) && (size_i <= SZ_W'(NLANE));

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign be_o[l] = legal_o && (l >= int'(off_i)) && (l < int'(off_i) + int'(size_i));
  end
endmodule

// File: rtl/lpc_lane_align.sv
module lpc_lane_align
  import lpc_bridge_pkg::*;
(
  input  logic [OFF_W:0]      size_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [DATA_W-1:0]   rd_rj_i,
  input  logic [DATA_W-1:0]   wr_lanes_i,
  output logic [DATA_W-1:0]   rd_lanes_o,
  output logic [DATA_W-1:0]   wr_rj_o
);
  localparam int unsigned SH_W = $clog2(DATA_W) + 1;

  logic [SH_W-1:0] sh_top, sh_off;
  // distance from right-justified position to lane 0; size 8 wraps to 0
  assign sh_top = SH_W'(DATA_W) - SH_W'({size_i, 3'b000});
  assign sh_off = SH_W'({off_i, 3'b000});

  assign rd_lanes_o = (rd_rj_i << sh_top) >> sh_off;
  assign wr_rj_o    = (wr_lanes_i << sh_off) >> sh_top;
endmodule

// File: rtl/lpc_ds_port.sv
module lpc_ds_port
  import lpc_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [DS_AW-1:0]  addr_i,
  input  logic [NLANE-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              we_o,
  output logic [DS_AW-1:0]  addr_o,
  output logic [NLANE-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      be_o    <= '0;
      wdata_o <= '0;
    end else if (!req_o) begin
      if (start_i) begin
        req_o   <= 1'b1;
        we_o    <= we_i;
        addr_o  <= addr_i;
        be_o    <= be_i;
        wdata_o <= wdata_i;
      end
    end else if (ack_i) begin
      req_o <= 1'b0;
    end
  end

  assign done_o = req_o & ack_i;

  assert_ds_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(be_o) &&
                           $stable(we_o) && $stable(wdata_o)));

  assert_be_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (be_o != '0));
endmodule

// File: rtl/lpc_reg_bridge.sv
module lpc_reg_bridge
  import lpc_bridge_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              reg_ack_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ds_req_o,
  output logic              ds_we_o,
  output logic [DS_AW-1:0]  ds_addr_o,
  output logic [NLANE-1:0]  ds_be_o,
  output logic [DATA_W-1:0] ds_wdata_o,
  input  logic              ds_ack_i,
  input  logic [DATA_W-1:0] ds_rdata_i,
  output logic              size_err_o,
  output logic              unimpl_o
);
  localparam int unsigned IDX_W = AW - 3;

  logic [IDX_W-1:0] idx;
  assign idx = reg_addr_i[AW-1:3];

  logic hit_base, hit_cmd, hit_data, hit_stat, hit_quiet, known;
  assign hit_base  = idx == IDX_W'(IDX_BASE);
  assign hit_cmd   = idx == IDX_W'(IDX_CMD);
  assign hit_data  = idx == IDX_W'(IDX_DATA);
  assign hit_stat  = idx == IDX_W'(IDX_STAT);
  assign hit_quiet = (idx == IDX_W'(IDX_Q0)) || (idx == IDX_W'(IDX_Q1)) ||
                     (idx == IDX_W'(IDX_Q2));
  assign known     = hit_base | hit_cmd | hit_data | hit_stat | hit_quiet;

  bridge_st_e st_q, st_d;
  logic [DATA_W-1:0] cmd_q, data_q, rdata_q;
  logic size_err_q, unimpl_q;

  logic accept, wr_acc;
  assign accept = (st_q == ST_IDLE) && reg_req_i;
  assign wr_acc = accept && reg_we_i;

  // a command write is checked against the new value, a data write against the latched one
  logic [DATA_W-1:0] cmd_src;
  assign cmd_src = hit_cmd ? reg_wdata_i : cmd_q;

  logic             size_ok;
  logic [NLANE-1:0] be_w;
  lpc_size_check u_chk (
    .size_i  (cmd_src[SZ_HI:SZ_LO]),
    .off_i   (cmd_src[OFF_W-1:0]),
    .legal_o (size_ok),
    .be_o    (be_w)
  );

  logic [DATA_W-1:0] rd_lanes, wr_rj;
  lpc_lane_align u_align (
    .size_i     (cmd_q[SZ_LO+OFF_W:SZ_LO]),
    .off_i      (cmd_q[OFF_W-1:0]),
    .rd_rj_i    (ds_rdata_i),
    .wr_lanes_i (reg_wdata_i),
    .rd_lanes_o (rd_lanes),
    .wr_rj_o    (wr_rj)
  );

  logic want_rd, want_wr, start_rd, start_wr, bad_size, ds_done;
  assign want_rd  = wr_acc && hit_cmd && reg_wdata_i[RD_BIT];
  assign want_wr  = wr_acc && hit_data && !cmd_q[RD_BIT];
  assign start_rd = want_rd && size_ok;
  assign start_wr = want_wr && size_ok;
  assign bad_size = (want_rd || want_wr) && !size_ok;

  lpc_ds_port u_ds (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_rd | start_wr),
    .we_i    (start_wr),
    .addr_i  (cmd_src[DS_AW-1:0]),
    .be_i    (be_w),
    .wdata_i (wr_rj),
    .ack_i   (ds_ack_i),
    .req_o   (ds_req_o),
    .we_o    (ds_we_o),
    .addr_o  (ds_addr_o),
    .be_o    (ds_be_o),
    .wdata_o (ds_wdata_o),
    .done_o  (ds_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = (start_rd || start_wr) ? ST_WAIT : ST_RESP;
      ST_WAIT: if (ds_done) st_d = ST_RESP;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cmd_q      <= '0;
      data_q     <= '0;
      rdata_q    <= '0;
      size_err_q <= 1'b0;
      unimpl_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_acc && hit_cmd) cmd_q <= reg_wdata_i;
      if (wr_acc && hit_data)            data_q <= reg_wdata_i;
      else if (ds_done && !ds_we_o)      data_q <= rd_lanes;
      if (accept) begin
        if (reg_we_i)      rdata_q <= '0;
        else if (hit_cmd)  rdata_q <= cmd_q;
        else if (hit_data) rdata_q <= data_q;
        else if (hit_stat) rdata_q <= STATUS_DONE;
        else               rdata_q <= '0;
      end
      if (bad_size)           size_err_q <= 1'b1;
      if (accept && !known)   unimpl_q   <= 1'b1;
    end
  end

  assign reg_ack_o   = st_q == ST_RESP;
  assign reg_rdata_o = rdata_q;
  assign size_err_o  = size_err_q;
  assign unimpl_o    = unimpl_q;

  logic unused_bits;
  assign unused_bits = ^{reg_addr_i[2:0], cmd_q[RD_BIT-1:SZ_HI+1], cmd_q[SZ_LO-1:DS_AW]};

  assert_ack_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ack_o |=> !reg_ack_o);

  assert_no_ack_in_flight_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_ack_o && ds_req_o));

  assert_size_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(size_err_o) |-> size_err_o);

  assert_unimpl_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(unimpl_o) |-> unimpl_o);
endmodule

// File: tb/sim_lpc_reg_bridge.sv
module sim_lpc_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic reg_ack;
  logic [63:0] reg_rdata;
  logic ds_req, ds_we, ds_ack = 1'b0;
  logic [31:0] ds_addr;
  logic [7:0] ds_be;
  logic [63:0] ds_wdata, ds_rdata = '0;
  logic size_err, unimpl;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_reg_bridge #(.AW(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_ack_o(reg_ack),
    .reg_rdata_o(reg_rdata), .ds_req_o(ds_req), .ds_we_o(ds_we),
    .ds_addr_o(ds_addr), .ds_be_o(ds_be), .ds_wdata_o(ds_wdata),
    .ds_ack_i(ds_ack), .ds_rdata_i(ds_rdata), .size_err_o(size_err),
    .unimpl_o(unimpl)
  );

  int checks = 0, fails = 0, ds_lat = 0;
  bit finished = 0;

  logic [63:0] rd_q[$];
  string       rtag_q[$];
  logic        dq_we[$];
  logic [31:0] dq_addr[$];
  logic [7:0]  dq_be[$];
  logic [63:0] dq_wd[$];
  string       dq_tag[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'h5A5A_C3C3, a + 32'h1111_1111};
  endfunction

  function automatic logic [63:0] mkcmd(input bit rd, input int sz, input logic [31:0] a);
    logic [6:0] s;
    s = 7'(sz);
    return {rd, 4'b0, s, 20'b0, a};
  endfunction

  function automatic logic [63:0] lanes_from_rj(input logic [63:0] rj, input int sz, input int off);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < sz; i++)
      if (off + i < 8) r[(7-off-i)*8 +: 8] = rj[(sz-1-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] rj_from_lanes(input logic [63:0] l, input int sz, input int off);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < sz; i++)
      if (off + i < 8) r[(sz-1-i)*8 +: 8] = l[(7-off-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] be_exp(input int sz, input int off);
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < sz; i++)
      if (off + i < 8) b[off+i] = 1'b1;
    return b;
  endfunction

  // driver: one register access, returns cycles from request to acknowledge
  task automatic xact(input bit w, input int idx, input logic [63:0] v, output int cyc);
    @(negedge clk);
    reg_req = 1'b1; reg_we = w; reg_addr = 16'(idx << 3); reg_wdata = v;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!reg_ack && cyc < 1000);
    reg_req = 1'b0;
  endtask

  task automatic reg_rd(input int idx, input logic [63:0] exp, input string tag);
    int c;
    rd_q.push_back(exp);
    rtag_q.push_back(tag);
    xact(1'b0, idx, '0, c);
    chk({tag, " R13 read latency"}, 64'(c), 64'd1);
  endtask

  task automatic exp_ds(input bit w, input logic [31:0] a, input logic [7:0] b,
                        input logic [63:0] wd, input string tag);
    dq_we.push_back(w); dq_addr.push_back(a); dq_be.push_back(b);
    dq_wd.push_back(wd); dq_tag.push_back(tag);
  endtask

  // monitor: register read results
  initial forever begin
    @(negedge clk);
    if (reg_ack && !reg_we) begin
      if (rd_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R13 unexpected read ack actual=%h expected=none", reg_rdata);
      end else chk(rtag_q.pop_front(), reg_rdata, rd_q.pop_front());
    end
    if (reg_ack && ds_req) begin
      checks++; fails++;
      $display("FAIL R12 ack during downstream actual=1 expected=0");
    end
  end

  // downstream model and monitor
  initial begin : ds_model
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      ds_ack = 1'b0;
      if (ds_req && rst_n) begin
        if (cnt >= ds_lat) begin
          ds_ack = 1'b1;
          ds_rdata = pat(ds_addr);
          cnt = 0;
          if (dq_we.size() == 0) begin
            checks++; fails++;
            $display("FAIL R8 unexpected downstream access actual=%h expected=none", ds_addr);
          end else begin
            string t;
            logic [63:0] wd;
            logic w;
            t = dq_tag.pop_front();
            w = dq_we.pop_front();
            wd = dq_wd.pop_front();
            chk({t, " R6 R7 direction"}, 64'(ds_we), 64'(w));
            chk({t, " R6 address"}, 64'(ds_addr), 64'(dq_addr.pop_front()));
            chk({t, " R11 byte enable"}, 64'(ds_be), 64'(dq_be.pop_front()));
            if (w) chk({t, " R10 write data"}, ds_wdata, wd);
          end
        end else cnt++;
      end
    end
  end

  task automatic do_read(input int sz, input logic [31:0] a, input int lat);
    int c;
    ds_lat = lat;
    exp_ds(1'b0, a, be_exp(sz, int'(a[2:0])), '0, "R6 read");
    xact(1'b1, 'h41, mkcmd(1'b1, sz, a), c);
    chk("R12 read stall", 64'(c), 64'(lat + 2));
    reg_rd('h42, lanes_from_rj(pat(a), sz, int'(a[2:0])), "R9 read lanes");
  endtask

  task automatic do_write(input int sz, input logic [31:0] a, input logic [63:0] v, input int lat);
    int c;
    ds_lat = lat;
    xact(1'b1, 'h41, mkcmd(1'b0, sz, a), c);
    chk("R7 write command only latches", 64'(c), 64'd1);
    exp_ds(1'b1, a, be_exp(sz, int'(a[2:0])), rj_from_lanes(v, sz, int'(a[2:0])), "R7 write");
    xact(1'b1, 'h42, v, c);
    chk("R12 write stall", 64'(c), 64'(lat + 2));
    reg_rd('h42, v, "R2 data readback");
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack", 64'(reg_ack), 64'd0);
    chk("R1 ds_req", 64'(ds_req), 64'd0);
    chk("R1 size_err", 64'(size_err), 64'd0);
    chk("R1 unimpl", 64'(unimpl), 64'd0);
    reg_rd('h41, '0, "R1 cmd reset");
    reg_rd('h42, '0, "R1 data reset");

    // base register and plain command latch
    xact(1'b1, 'h40, 64'hDEAD_BEEF_0123_4567, c);
    reg_rd('h40, '0, "R2 base reads zero");
    xact(1'b1, 'h41, 64'h0123_0000_0000_0042 & ~(64'h1 << 63), c);
    reg_rd('h41, 64'h0123_0000_0000_0042, "R2 cmd readback");

    // status
    reg_rd('h43, 64'h8000_0000_0000_0000, "R3 status");
    xact(1'b1, 'h43, 64'h0, c);
    reg_rd('h43, 64'h8000_0000_0000_0000, "R3 status after write");

    // quiet indices
    xact(1'b1, 'h12, '1, c);
    xact(1'b1, 'h13, '1, c);
    xact(1'b1, 'h18, '1, c);
    reg_rd('h12, '0, "R4 idx12");
    reg_rd('h13, '0, "R4 idx13");
    reg_rd('h18, '0, "R4 idx18");
    chk("R4 no unimpl flag", 64'(unimpl), 64'd0);

    // unknown indices
    reg_rd('h05, '0, "R5 unknown read");
    chk("R5 flag set", 64'(unimpl), 64'd1);
    xact(1'b1, 'h44, '1, c);
    reg_rd('h41, 64'h0123_0000_0000_0042, "R5 write ignored");
    chk("R5 flag stays", 64'(unimpl), 64'd1);

    // downstream reads across counts, offsets and latencies
    do_read(1, 32'h0000_1003, 0);
    do_read(2, 32'h0000_2006, 1);
    do_read(4, 32'h0000_3004, 3);
    do_read(8, 32'h0000_4000, 2);
    do_read(4, 32'h0000_5006, 0);
    do_read(8, 32'h0000_6005, 1);

    // downstream writes
    do_write(1, 32'h0000_7007, 64'h1122_3344_5566_7788, 0);
    do_write(2, 32'h0000_8002, 64'hA1B2_C3D4_E5F6_0718, 2);
    do_write(4, 32'h0000_9005, 64'h0F1E_2D3C_4B5A_6978, 1);
    do_write(8, 32'h0000_A000, 64'hFEDC_BA98_7654_3210, 4);

    // data write with read flag set only latches
    do_read(2, 32'h0000_B000, 0);
    xact(1'b1, 'h42, 64'h5555_AAAA_5555_AAAA, c);
    chk("R7 read flag data write no stall", 64'(c), 64'd1);
    reg_rd('h42, 64'h5555_AAAA_5555_AAAA, "R7 latch only");

    // illegal counts
    chk("R8 flag clear before", 64'(size_err), 64'd0);
    xact(1'b1, 'h41, mkcmd(1'b1, 3, 32'h0000_C000), c);
    chk("R8 count 3 no stall", 64'(c), 64'd1);
    reg_rd('h42, 64'h5555_AAAA_5555_AAAA, "R8 data unchanged");
    chk("R8 flag set", 64'(size_err), 64'd1);
    xact(1'b1, 'h41, mkcmd(1'b1, 16, 32'h0000_C008), c);
    xact(1'b1, 'h41, mkcmd(1'b1, 0, 32'h0000_C010), c);
    reg_rd('h42, 64'h5555_AAAA_5555_AAAA, "R8 data unchanged 16 and 0");
    xact(1'b1, 'h41, mkcmd(1'b0, 6, 32'h0000_C018), c);
    xact(1'b1, 'h42, 64'h0707_0707_0707_0707, c);
    chk("R8 illegal write no stall", 64'(c), 64'd1);
    chk("R8 flag stays", 64'(size_err), 64'd1);

    repeat (4) @(negedge clk);
    chk("R6 R7 no pending downstream", 64'(dq_we.size()), 64'd0);
    chk("R13 no pending reads", 64'(rd_q.size()), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule